// File: doc/BRIEF.md
# Infrared Pulse-Width Capture Engine

The engine watches a raw infrared receiver line and measures how long each mark (line high) and each space (line low) lasts. Time is counted in sample ticks, and a programmable period sets their length. Each measured width goes into a capture bank as one byte. The bytes alternate mark, space, mark, and so on, starting with the first accepted mark. Software reads the bank one 32-bit word at a time. Word `k` holds entries `4k` to `4k+3`, and the earliest entry sits in the lowest byte.

Before anything is measured, a de-glitch filter drops short excursions on the line. A message ends when a space outlasts a programmable completion threshold. That space is stored as `0x00`, and a sticky status flag is set. The flag drives the interrupt output when the interrupt enable is set. If the bank fills first, the engine stops storing and waits for the same idle timeout. After completion the engine ignores the line until software writes the restart bit, which clears the bank and re-arms the engine.

The controller states are `S_IDLE`, `S_MARK`, `S_SPACE`, `S_FULL` and `S_DONE`. The transitions are:
- arm: `S_IDLE`→`S_MARK`, on the first accepted rising edge.
- mark_end: `S_MARK`→`S_SPACE`, which stores the mark.
- space_end: `S_SPACE`→`S_MARK`, which stores the space.
- fill: `S_SPACE`→`S_FULL`, on storing the last entry.
- timeout: `S_SPACE`→`S_DONE`, which stores `0x00`.
- full_timeout: `S_FULL`→`S_DONE`.
- rearm: any state→`S_IDLE`, on restart.

Register writes use `wr_en`, `wr_addr` and `wr_data`:
- Address 0 is the control register:
  - bit 0: receive enable
  - bit 1: width-measure enable
  - bits 6:2: de-glitch count `D`
  - bits 14:8: completion count `C`
- Address 1 holds the tick period `P` (bits 15:0).
- Address 2 is restart (bit 0).
- Address 3 is the interrupt enable (bit 0).
- Address 4 is the interrupt clear (bit 0).

Reads are combinational. Addresses 0–16 return bank words, and address 17 returns the status flag in bit 0.

Top module: `irpw_capture`

## Requirements
- R1: A sample tick occurs once every `P+1` clock cycles. Widths are counted in ticks.
- R2: Entry `k` is stored in bank word `k/4`, bits `8*(k%4)+7 : 8*(k%4)`. Even entries are marks, odd entries are spaces, and entry 0 is the first mark.
- R3: A mark or space longer than 255 ticks is stored as `0xFF`.
- R4: A space of up to `4*C` ticks that is followed by a mark is stored with its width. A longer space is stored as `0x00`, ends the message, leaves all later entries `0x00`, and sets the status flag.
- R5: Only the first 68 entries are stored. Later marks and spaces are discarded, and completion still follows once a space exceeds `4*C` ticks.
- R6: A level change is accepted only after the input has differed from the accepted level on `D+1` consecutive ticks. Shorter excursions are ignored and do not split a width.
- R7: Unless control bits 0 and 1 are both 1, the input line is ignored: the bank is not written and the status flag is not set.
- R8: Writing 1 to restart bit 0 clears every bank word and re-arms capture. After completion, further input changes no bank entry until restart.
- R9: The status flag (read address 17, bit 0) stays set until 1 is written to interrupt clear bit 0. `irq` equals status AND the interrupt enable bit.
- R10: After reset or restart, the line is taken as idle (low). Capture begins only at an accepted rising edge, and the reset state has an all-zero bank, status 0 and `irq` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ir_in | input | 1 | Raw receiver line, high = mark |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 5 | Read address (bank word or status) |
| rd_data | output | 32 | Read data, combinational |
| irq | output | 1 | Completion interrupt |

## Verification
The input passes two synchronizer flops and then the `D+1` accepting ticks. Every edge is therefore delayed by the same amount, so a level held for N ticks is stored as exactly N, one tick after the following edge is accepted. Completion comes `4*C+1` ticks after the accepted start of the final space, and register writes take effect at the next edge. The bench drives inputs on falling edges and holds each level for a whole number of tick periods. It reads the bank and status only after a trailing idle time well beyond the completion window. In the boundary case, a space of exactly `4*C` ticks and one of `4*C+1` ticks separate storing from completing.

// File: rtl/irpw_pkg.sv
package irpw_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_MARK,
        S_SPACE,
        S_FULL,
        S_DONE
    } cap_state_t;

    localparam logic [2:0] A_CTRL    = 3'd0;
    localparam logic [2:0] A_PERIOD  = 3'd1;
    localparam logic [2:0] A_RESTART = 3'd2;
    localparam logic [2:0] A_IRQEN   = 3'd3;
    localparam logic [2:0] A_IRQCLR  = 3'd4;
endpackage

// File: rtl/irpw_tick.sv
module irpw_tick #(
    parameter int PER_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [PER_W-1:0] period,
    output logic             tick
);
    logic [PER_W-1:0] cnt_q;

    assign tick = run && (cnt_q >= period);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt_q <= '0;
        else if (!run)   cnt_q <= '0;
        else if (tick)   cnt_q <= '0;
        else             cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/irpw_deglitch.sv
module irpw_deglitch #(
    parameter int DG_W = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            raw,
    input  logic            tick,
    input  logic [DG_W-1:0] dg,
    output logic            level,
    output logic            flip
);
    logic [1:0]      sync_q;
    logic [DG_W-1:0] dcnt_q;
    logic            samp;

    assign samp = sync_q[1];
    // the tick on which a new level is accepted
    assign flip = tick && (samp != level) && (dcnt_q >= dg);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
            dcnt_q <= '0;
            level  <= 1'b0;
        end else begin
            sync_q <= {sync_q[0], raw};
            if (tick) begin
                if (samp == level) begin
                    dcnt_q <= '0;
                end else if (flip) begin
                    level  <= samp;
                    dcnt_q <= '0;
                end else begin
                    dcnt_q <= dcnt_q + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/irpw_bank.sv
module irpw_bank #(
    parameter int N_WORDS = 17,
    parameter int WS_W    = 5,
    parameter int RD_W    = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            we,
    input  logic [WS_W-1:0] wsel,
    input  logic [1:0]      wlane,
    input  logic [7:0]      wbyte,
    input  logic [RD_W-1:0] rsel,
    output logic [31:0]     rdata
);
    logic [31:0] mem [N_WORDS];

    for (genvar w = 0; w < N_WORDS; w++) begin : g_word
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                          mem[w] <= '0;
            else if (clr)                        mem[w] <= '0;
            else if (we && wsel == WS_W'(w))     mem[w][8*wlane +: 8] <= wbyte;
        end
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < N_WORDS; i++) begin
            if (rsel == RD_W'(i)) rdata = mem[i];
        end
    end
endmodule

// File: rtl/irpw_capture.sv
module irpw_capture
    import irpw_pkg::*;
#(
    parameter int N_WORDS    = 17,
    parameter int CNT_W      = 12,
    parameter int DONE_SHIFT = 2,
    parameter int PER_W      = 16,
    parameter int DG_W       = 5,
    parameter int DONE_W     = 7,
    parameter int RD_W       = $clog2(N_WORDS + 2)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ir_in,
    input  logic             wr_en,
    input  logic [2:0]       wr_addr,
    input  logic [PER_W-1:0] wr_data,
    input  logic [RD_W-1:0]  rd_addr,
    output logic [31:0]      rd_data,
    output logic             irq
);
    localparam int N_ENT = N_WORDS * 4;
    localparam int IDX_W = $clog2(N_ENT + 1);
    localparam int WS_W  = IDX_W - 2;

    // register file
    logic              rx_en_q, pw_en_q, irq_en_q, status_q;
    logic [DG_W-1:0]   dg_q;
    logic [DONE_W-1:0] done_q;
    logic [PER_W-1:0]  per_q;
    logic              restart, irq_clr;

    // engine state
    cap_state_t        state_q, state_d;
    logic [IDX_W-1:0]  idx_q, idx_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d, cnt_inc, thr;
    logic              bank_we, done_evt;
    logic [7:0]        bank_byte;
    logic              tick, level, flip;
    logic [31:0]       bank_rdata;

    assign restart = wr_en && (wr_addr == A_RESTART) && wr_data[0];
    assign irq_clr = wr_en && (wr_addr == A_IRQCLR) && wr_data[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_en_q  <= 1'b0;
            pw_en_q  <= 1'b0;
            dg_q     <= '0;
            done_q   <= '0;
            per_q    <= '0;
            irq_en_q <= 1'b0;
        end else if (wr_en) begin
            if (wr_addr == A_CTRL) begin
                rx_en_q <= wr_data[0];
                pw_en_q <= wr_data[1];
                dg_q    <= wr_data[2 +: DG_W];
                done_q  <= wr_data[8 +: DONE_W];
            end
            if (wr_addr == A_PERIOD) per_q    <= wr_data;
            if (wr_addr == A_IRQEN)  irq_en_q <= wr_data[0];
        end
    end

    irpw_tick #(.PER_W(PER_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .run(rx_en_q && pw_en_q),
        .period(per_q), .tick(tick)
    );

    irpw_deglitch #(.DG_W(DG_W)) u_dg (
        .clk(clk), .rst_n(rst_n), .raw(ir_in), .tick(tick),
        .dg(dg_q), .level(level), .flip(flip)
    );

    irpw_bank #(.N_WORDS(N_WORDS), .WS_W(WS_W), .RD_W(RD_W)) u_bank (
        .clk(clk), .rst_n(rst_n), .clr(restart), .we(bank_we),
        .wsel(idx_q[IDX_W-1:2]), .wlane(idx_q[1:0]), .wbyte(bank_byte),
        .rsel(rd_addr), .rdata(bank_rdata)
    );

    assign thr     = CNT_W'(done_q) << DONE_SHIFT;
    assign cnt_inc = (cnt_q == '1) ? cnt_q : cnt_q + 1'b1;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= S_IDLE;
            idx_q    <= '0;
            cnt_q    <= '0;
            status_q <= 1'b0;
        end else begin
            state_q  <= state_d;
            idx_q    <= idx_d;
            cnt_q    <= cnt_d;
            if (done_evt)     status_q <= 1'b1;
            else if (irq_clr) status_q <= 1'b0;
        end
    end

    // next state and outputs
    always_comb begin
        state_d   = state_q;
        idx_d     = idx_q;
        cnt_d     = cnt_q;
        bank_we   = 1'b0;
        done_evt  = 1'b0;
        bank_byte = (cnt_q > CNT_W'(255)) ? 8'hFF : cnt_q[7:0];
        if (restart) begin
            state_d = S_IDLE;                       // rearm
            idx_d   = '0;
            cnt_d   = '0;
        end else if (tick) begin
            unique case (state_q)
                S_IDLE: begin
                    if (flip && !level) begin        // arm
                        state_d = S_MARK;
                        cnt_d   = CNT_W'(1);
                    end
                end
                S_MARK: begin
                    if (flip) begin                  // mark_end
                        bank_we = 1'b1;
                        idx_d   = idx_q + 1'b1;
                        cnt_d   = CNT_W'(1);
                        state_d = S_SPACE;
                    end else begin
                        cnt_d   = cnt_inc;
                    end
                end
                S_SPACE: begin
                    if (flip) begin                  // space_end / fill
                        bank_we = 1'b1;
                        idx_d   = idx_q + 1'b1;
                        cnt_d   = CNT_W'(1);
                        state_d = (idx_q == IDX_W'(N_ENT - 1)) ? S_FULL : S_MARK;
                    end else if (cnt_inc > thr) begin // timeout
                        bank_we   = 1'b1;
                        bank_byte = 8'h00;
                        done_evt  = 1'b1;
                        state_d   = S_DONE;
                    end else begin
                        cnt_d   = cnt_inc;
                    end
                end
                S_FULL: begin
                    if (flip) begin
                        cnt_d = CNT_W'(1);
                    end else if (!level && cnt_inc > thr) begin // full_timeout
                        done_evt = 1'b1;
                        state_d  = S_DONE;
                    end else begin
                        cnt_d = cnt_inc;
                    end
                end
                S_DONE: begin
                end
                default: state_d = S_IDLE;
            endcase
        end
    end

    assign irq     = status_q && irq_en_q;
    assign rd_data = (rd_addr == RD_W'(N_WORDS)) ? {31'd0, status_q} : bank_rdata;
endmodule

// File: rtl/irpw_capture_chk.sv
module irpw_capture_chk
    import irpw_pkg::*;
#(
    parameter int N_WORDS = 17,
    parameter int IDX_W   = 7
) (
    input logic             clk,
    input logic             rst_n,
    input cap_state_t       state,
    input logic [IDX_W-1:0] idx,
    input logic             status,
    input logic             restart,
    input logic             clr,
    input logic             we,
    input logic             irq,
    input logic             irq_en
);
    localparam int N_ENT = N_WORDS * 4;

    p_idx_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        idx <= IDX_W'(N_ENT));

    p_mark_even_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (we && state == S_MARK) |-> !idx[0]);

    p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (status && !clr) |=> status);

    p_irq_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> !irq);

    p_done_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_DONE && !restart) |=> state == S_DONE);

    p_rearm_r8: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (idx == '0 && state == S_IDLE));

    p_status_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status) |-> state == S_DONE);
endmodule

bind irpw_capture irpw_capture_chk #(.N_WORDS(N_WORDS), .IDX_W(IDX_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .state(state_q), .idx(idx_q),
    .status(status_q), .restart(restart), .clr(irq_clr), .we(bank_we),
    .irq(irq), .irq_en(irq_en_q)
);

// File: tb/irpw_capture_tb.sv
`timescale 1ns/1ps
module irpw_capture_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ir_in = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [4:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;
    logic [7:0] eb [68];

    always #2.5 clk = ~clk;

    irpw_capture u_dut (
        .clk(clk), .rst_n(rst_n), .ir_in(ir_in), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_addr = a;
        #1 d = rd_data;
    endtask

    task automatic drive(input logic lv, input int n);
        ir_in = lv;
        repeat (n) @(negedge clk);
    endtask

    task automatic setup(input int per, input int dg, input int done, input int en, input int ien);
        drive(1'b0, 4);
        wr(3'd1, 16'(per));
        wr(3'd0, 16'((done << 8) | (dg << 2) | en));
        wr(3'd3, 16'(ien));
        wr(3'd2, 16'd1);
        wr(3'd4, 16'd1);
        for (int i = 0; i < 68; i++) eb[i] = 8'h00;
    endtask

    task automatic check_bank(input string tag);
        logic [31:0] d;
        for (int w = 0; w < 17; w++) begin
            rd(5'(w), d);
            chk(tag, d, {eb[4*w+3], eb[4*w+2], eb[4*w+1], eb[4*w]});
        end
    endtask

    task automatic t_reset;
        logic [31:0] d;
        check_bank("R10 reset bank");
        rd(5'd17, d);
        chk("R10 reset status", d, 32'd0);
        chk("R10 reset irq", {31'd0, irq}, 32'd0);
    endtask

    task automatic t_basic;
        logic [31:0] d;
        setup(0, 0, 2, 3, 1);                 // threshold 8 ticks
        drive(1, 4); drive(0, 8); drive(1, 4); drive(0, 60);
        eb[0] = 4; eb[1] = 8; eb[2] = 4;
        check_bank("R2 R4 space of threshold stored");
        rd(5'd17, d);
        chk("R4 status set", d, 32'd1);
        chk("R9 irq raised", {31'd0, irq}, 32'd1);
        setup(0, 0, 2, 3, 1);
        drive(1, 4); drive(0, 9); drive(1, 4); drive(0, 60);
        eb[0] = 4;
        check_bank("R4 R8 space over threshold ends, later input ignored");
    endtask

    task automatic t_sat;
        setup(0, 0, 127, 3, 1);
        drive(1, 300); drive(0, 260); drive(1, 2); drive(0, 600);
        eb[0] = 8'hFF; eb[1] = 8'hFF; eb[2] = 2;
        check_bank("R3 saturation");
    endtask

    task automatic t_period;
        setup(3, 0, 20, 3, 1);
        drive(1, 40); drive(0, 24); drive(1, 12); drive(0, 400);
        eb[0] = 10; eb[1] = 6; eb[2] = 3;
        check_bank("R1 tick period");
    endtask

    task automatic t_deglitch;
        setup(0, 3, 10, 3, 1);
        drive(1, 2); drive(0, 10);
        drive(1, 8); drive(0, 2); drive(1, 10);
        drive(0, 10); drive(1, 6); drive(0, 100);
        eb[0] = 20; eb[1] = 10; eb[2] = 6;
        check_bank("R6 deglitch");
    endtask

    task automatic t_overflow;
        logic [31:0] d;
        setup(0, 0, 10, 3, 1);
        for (int p = 0; p < 40; p++) begin
            drive(1, 3); drive(0, 2);
        end
        drive(0, 80);
        for (int i = 0; i < 68; i++) eb[i] = (i % 2 == 0) ? 8'd3 : 8'd2;
        check_bank("R5 first 68 kept");
        rd(5'd17, d);
        chk("R5 completion after full", d, 32'd1);
    endtask

    task automatic t_irq;
        logic [31:0] d;
        setup(0, 0, 2, 3, 0);
        drive(1, 5); drive(0, 60);
        chk("R9 irq masked", {31'd0, irq}, 32'd0);
        rd(5'd17, d);
        chk("R9 status sticky", d, 32'd1);
        wr(3'd3, 16'd1);
        chk("R9 irq after enable", {31'd0, irq}, 32'd1);
        wr(3'd4, 16'd1);
        rd(5'd17, d);
        chk("R9 status cleared", d, 32'd0);
        chk("R9 irq after clear", {31'd0, irq}, 32'd0);
    endtask

    task automatic t_enable;
        logic [31:0] d;
        setup(0, 0, 2, 1, 1);
        drive(1, 5); drive(0, 5); drive(1, 5); drive(0, 60);
        check_bank("R7 width enable off");
        rd(5'd17, d);
        chk("R7 no status", d, 32'd0);
        setup(0, 0, 2, 2, 1);
        drive(1, 5); drive(0, 5); drive(1, 5); drive(0, 60);
        check_bank("R7 receive enable off");
    endtask

    task automatic t_restart;
        setup(0, 0, 2, 3, 1);
        drive(1, 7); drive(0, 3); drive(1, 7); drive(0, 60);
        wr(3'd2, 16'd1);
        check_bank("R8 restart clears bank");
        drive(1, 5); drive(0, 60);
        eb[0] = 5;
        check_bank("R8 R10 new message after restart");
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_basic();
        t_sat();
        t_period();
        t_deglitch();
        t_overflow();
        t_irq();
        t_enable();
        t_restart();
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end
endmodule